// File: doc/BRIEF.md
# Host FIFO Status and Service Request Logic

This block builds the status byte that an external host reads to learn the state of a pair of FIFOs it shares with a local processor. The input FIFO carries data from the host, and the output FIFO carries data back to it. The block takes fill levels, programmable thresholds, error event pulses, command-register flags and a freeze flag. It turns them into active-low status bits. Error bits stay latched until the host reads the status. The local processor sees the same byte through its own view, which differs in the command-in bit and in the freeze bit.

The block drives two service-request lines, one per FIFO direction. With DMA enabled, each line is a plain DMA request. With DMA disabled, each line becomes a dedicated service interrupt, gated by its own bit of a host-written enable mask. A general interrupt line combines the error, command-out and freeze sources under the same mask. While freeze mode is active, the host's status byte reads all ones and both request lines are held low, so the host leaves the FIFOs alone.

Top module: `hfs_top`

## Requirements
- R1: While reset is asserted, `host_status` bit 2 reads 1 and `cpu_status` bit 2 reads 0. Both error bits (7 and 3) read 1.
- R2: An `udr_evt` pulse makes status bit 7 read 0 from the next clock. It stays 0 without further pulses until it is cleared as R4 describes.
- R3: An `ovr_evt` pulse makes status bit 3 read 0 from the next clock. It stays latched in the same way as bit 7.
- R4: A `host_rd` strobe sampled at a clock edge while freeze is low makes both error bits read 1 after that edge. An error pulse in the same cycle as the strobe wins, and its bit stays 0.
- R5: Status bit 0 is 0 when `in_free` >= `in_thr` and 1 otherwise. The request this bit reports is called the input request.
- R6: Status bit 4 is 0 when `out_cnt` >= `out_thr`, or when `out_flush` is high whatever the threshold. It is 1 otherwise. The request this bit reports is called the output request.
- R7: Bit 6 is the inverse of `cmd_out_full`, and bit 5 is the inverse of `out_dsc_head`. Bit 2 of both views follows `cmd_in_full`, one clock late.
- R8: While `freeze` is high, `host_status` is 8'hFF and `cpu_status` bit 1 is 1. With freeze low, bit 1 is 0 in both views. A host read during freeze does not clear the error bits.
- R9: With `dma_en` high, `req_in` and `req_out` equal the input and output requests, active high. Both are forced low during freeze.
- R10: With `dma_en` low, `req_in` is the input request ANDed with `irq_mask[0]`, and `req_out` is the output request ANDed with `irq_mask[1]`.
- R11: `irq` is the OR of the overrun latch ANDed with mask bit 2, the underrun latch ANDed with mask bit 3, `cmd_out_full` ANDed with mask bit 4, and `freeze` ANDed with mask bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_free | input | PTR_W+1 | Free bytes in the input FIFO |
| in_thr | input | PTR_W+1 | Input request threshold |
| out_cnt | input | PTR_W+1 | Bytes held in the output FIFO |
| out_thr | input | PTR_W+1 | Output request threshold |
| out_flush | input | 1 | Local CPU closed a block with a stream command |
| out_dsc_head | input | 1 | Stream command at the output FIFO head |
| udr_evt | input | 1 | Output FIFO underrun pulse |
| ovr_evt | input | 1 | Input FIFO overrun pulse |
| cmd_out_full | input | 1 | Immediate command waiting for the host |
| cmd_in_full | input | 1 | Host command not yet read by the local CPU |
| freeze | input | 1 | Freeze mode active |
| host_rd | input | 1 | Host status-read strobe |
| dma_en | input | 1 | Request lines act as DMA requests |
| irq_mask | input | 6 | Interrupt enable mask |
| host_status | output | 8 | Status byte seen by the host |
| cpu_status | output | 8 | Status byte seen by the local CPU |
| req_in | output | 1 | Input FIFO service request |
| req_out | output | 1 | Output FIFO service request |
| irq | output | 1 | General interrupt |

## Verification
Two functions can fall in the same cycle: the host's status read, which clears the error latches, and a new error event, which sets them. The bench drives `ovr_evt` and `host_rd` in the same cycle. A reference model in which setting wins then expects bit 3 to stay 0. A second collision puts a host read inside freeze mode, where the errors must survive, and a read after freeze then confirms that the latch still holds the error.

// File: rtl/hfs_pkg.sv
package hfs_pkg;
  // status bit positions; host software decodes these
  localparam int ST_INREQ  = 0;
  localparam int ST_FRZ    = 1;
  localparam int ST_CMDIN  = 2;
  localparam int ST_OVR    = 3;
  localparam int ST_OUTREQ = 4;
  localparam int ST_DSC    = 5;
  localparam int ST_CMDOUT = 6;
  localparam int ST_UDR    = 7;
  // interrupt mask positions
  localparam int IRQ_N     = 6;
  localparam int IQ_IN     = 0;
  localparam int IQ_OUT    = 1;
  localparam int IQ_OVR    = 2;
  localparam int IQ_UDR    = 3;
  localparam int IQ_CMD    = 4;
  localparam int IQ_FRZ    = 5;
  localparam int N_ERR     = 2;
  localparam int E_OVR     = 0;
  localparam int E_UDR     = 1;
endpackage

// File: rtl/hfs_err_latch.sv
module hfs_err_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr,
  output logic flag
);
  logic flag_nxt;
  logic flag_en;

  always_comb begin
    flag_en  = evt | clr;
    flag_nxt = evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (flag_en) flag <= flag_nxt;
  end

  // R2
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag);
  // R4
  err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt) |=> !flag);
endmodule

// File: rtl/hfs_req.sv
module hfs_req #(
  parameter int CW = 5
) (
  input  logic [CW-1:0] in_free,
  input  logic [CW-1:0] in_thr,
  input  logic [CW-1:0] out_cnt,
  input  logic [CW-1:0] out_thr,
  input  logic          out_flush,
  input  logic          freeze,
  output logic          rq_in,
  output logic          rq_out
);
  always_comb begin
    rq_in  = !freeze && (in_free >= in_thr);
    rq_out = !freeze && ((out_cnt >= out_thr) || out_flush);
  end
endmodule

// File: rtl/hfs_top.sv
module hfs_top
  import hfs_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PTR_W:0]      in_free,
  input  logic [PTR_W:0]      in_thr,
  input  logic [PTR_W:0]      out_cnt,
  input  logic [PTR_W:0]      out_thr,
  input  logic                out_flush,
  input  logic                out_dsc_head,
  input  logic                udr_evt,
  input  logic                ovr_evt,
  input  logic                cmd_out_full,
  input  logic                cmd_in_full,
  input  logic                freeze,
  input  logic                host_rd,
  input  logic                dma_en,
  input  logic [IRQ_N-1:0]    irq_mask,
  output logic [7:0]          host_status,
  output logic [7:0]          cpu_status,
  output logic                req_in,
  output logic                req_out,
  output logic                irq
);
  localparam int CW = PTR_W + 1;

  logic [N_ERR-1:0] err_evt;
  logic [N_ERR-1:0] err_flag;
  logic             err_clr;
  logic             rq_in, rq_out;
  logic             cin_host, cin_cpu;
  logic [7:0]       stat_core;
  logic [IRQ_N-1:0] irq_src;

  assign err_evt[E_OVR] = ovr_evt;
  assign err_evt[E_UDR] = udr_evt;
  assign err_clr        = host_rd & ~freeze;

  for (genvar g = 0; g < N_ERR; g++) begin : g_err
    hfs_err_latch u_lat (
      .clk  (clk),
      .rst_n(rst_n),
      .evt  (err_evt[g]),
      .clr  (err_clr),
      .flag (err_flag[g])
    );
  end

  hfs_req #(.CW(CW)) u_req (
    .in_free  (in_free),
    .in_thr   (in_thr),
    .out_cnt  (out_cnt),
    .out_thr  (out_thr),
    .out_flush(out_flush),
    .freeze   (freeze),
    .rq_in    (rq_in),
    .rq_out   (rq_out)
  );

  // command-in views: host copy resets to 1, CPU shadow resets to 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cin_host <= 1'b1;
      cin_cpu  <= 1'b0;
    end else begin
      cin_host <= cmd_in_full;
      cin_cpu  <= cmd_in_full;
    end
  end

  always_comb begin
    stat_core            = '0;
    stat_core[ST_UDR]    = ~err_flag[E_UDR];
    stat_core[ST_CMDOUT] = ~cmd_out_full;
    stat_core[ST_DSC]    = ~out_dsc_head;
    stat_core[ST_OUTREQ] = ~rq_out;
    stat_core[ST_OVR]    = ~err_flag[E_OVR];
    stat_core[ST_INREQ]  = ~rq_in;

    host_status            = stat_core;
    host_status[ST_CMDIN]  = cin_host;
    if (freeze) host_status = '1;

    cpu_status             = stat_core;
    cpu_status[ST_CMDIN]   = cin_cpu;
    cpu_status[ST_FRZ]     = freeze;

    irq_src          = '0;
    irq_src[IQ_IN]   = rq_in;
    irq_src[IQ_OUT]  = rq_out;
    irq_src[IQ_OVR]  = err_flag[E_OVR];
    irq_src[IQ_UDR]  = err_flag[E_UDR];
    irq_src[IQ_CMD]  = cmd_out_full;
    irq_src[IQ_FRZ]  = freeze;

    req_in  = dma_en ? rq_in  : (rq_in  & irq_mask[IQ_IN]);
    req_out = dma_en ? rq_out : (rq_out & irq_mask[IQ_OUT]);
    irq     = |(irq_src[IRQ_N-1:IQ_OVR] & irq_mask[IRQ_N-1:IQ_OVR]);
  end

  // R7
  cmdin_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cpu_status[ST_CMDIN] == $past(cmd_in_full)));
  // R8
  frz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && $past(freeze) && !ovr_evt && !$past(ovr_evt)) |=>
      (cpu_status[ST_OVR] == $past(cpu_status[ST_OVR])) || !freeze);
  // R9
  frz_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> (!req_in && !req_out && host_status[ST_FRZ]));
  // R3
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> !cpu_status[ST_OVR]);
endmodule

// File: tb/hfs_top_test.sv
module hfs_top_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] in_free, in_thr, out_cnt, out_thr;
  logic       out_flush, out_dsc_head, udr_evt, ovr_evt;
  logic       cmd_out_full, cmd_in_full, freeze, host_rd, dma_en;
  logic [5:0] irq_mask;
  logic [7:0] host_status, cpu_status;
  logic       req_in, req_out, irq;

  typedef struct packed {
    logic [7:0] hs;
    logic [7:0] cs;
    logic       ri;
    logic       ro;
    logic       iq;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  int    checks = 0;
  int    errors = 0;
  bit    m_udr, m_ovr, m_ch, m_cc;

  always #4 clk = ~clk;

  hfs_top #(.PTR_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .in_free(in_free), .in_thr(in_thr),
    .out_cnt(out_cnt), .out_thr(out_thr), .out_flush(out_flush),
    .out_dsc_head(out_dsc_head), .udr_evt(udr_evt), .ovr_evt(ovr_evt),
    .cmd_out_full(cmd_out_full), .cmd_in_full(cmd_in_full), .freeze(freeze),
    .host_rd(host_rd), .dma_en(dma_en), .irq_mask(irq_mask),
    .host_status(host_status), .cpu_status(cpu_status),
    .req_in(req_in), .req_out(req_out), .irq(irq)
  );

  function automatic exp_t model();
    exp_t e;
    logic ri, ro;
    ri = !freeze && (in_free >= in_thr);
    ro = !freeze && ((out_cnt >= out_thr) || out_flush);
    e.cs = {~m_udr, ~cmd_out_full, ~out_dsc_head, ~ro, ~m_ovr, m_cc, freeze, ~ri};
    e.hs = freeze ? 8'hFF : {e.cs[7:3], m_ch, 1'b0, ~ri};
    e.ri = dma_en ? ri : (ri & irq_mask[0]);
    e.ro = dma_en ? ro : (ro & irq_mask[1]);
    e.iq = |({freeze, cmd_out_full, m_udr, m_ovr} & irq_mask[5:2]);
    return e;
  endfunction

  task automatic check(input exp_t e, input string tag);
    exp_t a;
    a = '{hs: host_status, cs: cpu_status, ri: req_in, ro: req_out, iq: irq};
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s: got hs=%h cs=%h ri=%b ro=%b irq=%b expected hs=%h cs=%h ri=%b ro=%b irq=%b",
               tag, a.hs, a.cs, a.ri, a.ro, a.iq, e.hs, e.cs, e.ri, e.ro, e.iq);
    end
  endtask

  // driver: inputs already set at negedge; advance model at the edge
  task automatic step(input string tag);
    @(posedge clk);
    if (ovr_evt) m_ovr = 1'b1; else if (host_rd && !freeze) m_ovr = 1'b0;
    if (udr_evt) m_udr = 1'b1; else if (host_rd && !freeze) m_udr = 1'b0;
    m_ch = cmd_in_full;
    m_cc = cmd_in_full;
    expq.push_back(model());
    tagq.push_back(tag);
    @(negedge clk);
    udr_evt = 0; ovr_evt = 0; host_rd = 0;
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (expq.size() > 0) check(expq.pop_front(), tagq.pop_front());
  end

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; in_free = 0; in_thr = 4; out_cnt = 0; out_thr = 4;
    out_flush = 0; out_dsc_head = 0; udr_evt = 0; ovr_evt = 0;
    cmd_out_full = 0; cmd_in_full = 0; freeze = 0; host_rd = 0;
    dma_en = 1; irq_mask = 6'h00;
    m_udr = 0; m_ovr = 0; m_ch = 1; m_cc = 0;
    repeat (3) @(negedge clk);
    check(model(), "R1 reset");
    rst_n = 1;
    step("R1 idle");
    in_free = 4; step("R5 free==thr");
    in_free = 3; step("R5 free<thr");
    in_thr = 0; in_free = 0; step("R5 zero thr");
    in_thr = 8; out_cnt = 5; out_thr = 5; step("R6 cnt==thr");
    out_cnt = 4; step("R6 cnt<thr");
    out_flush = 1; out_thr = 16; step("R6 flush");
    out_flush = 0; cmd_out_full = 1; out_dsc_head = 1; step("R7 cmd out/dsc");
    cmd_in_full = 1; step("R7 cmd in");
    cmd_in_full = 0; cmd_out_full = 0; out_dsc_head = 0; step("R7 cleared");
    udr_evt = 1; step("R2 underrun set");
    step("R2 underrun held");
    host_rd = 1; step("R4 read clears");
    ovr_evt = 1; step("R3 overrun set");
    ovr_evt = 1; host_rd = 1; step("R4 event beats read");
    host_rd = 1; step("R4 read clears overrun");
    udr_evt = 1; ovr_evt = 1; step("R2 both errors");
    freeze = 1; in_free = 16; in_thr = 1; step("R8 freeze forces ones");
    host_rd = 1; step("R8 read in freeze");
    freeze = 0; step("R8 errors kept after freeze");
    dma_en = 1; step("R9 dma requests");
    dma_en = 0; irq_mask = 6'b000001; step("R10 in gated");
    irq_mask = 6'b000010; out_cnt = 16; out_thr = 2; step("R10 out gated");
    irq_mask = 6'b001100; step("R11 error irq");
    host_rd = 1; step("R11 irq drops after read");
    irq_mask = 6'b110000; cmd_out_full = 1; step("R11 cmd irq");
    cmd_out_full = 0; freeze = 1; step("R11 freeze irq");
    freeze = 0; irq_mask = 6'b000000; step("R11 all masked");
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule